// File: doc/BRIEF.md
# Dual-Channel Host Register Access Decoder

This block sits between a host's 8-bit parallel bus and the two serial channels of a dual serial controller. It watches an active-low chip select, a channel-select line, active-low read and write strobes, a register address and write data. Each new strobe assertion becomes a one-cycle read or write enable to the selected channel, with the captured address and data presented alongside. Read data from the addressed channel is steered back to the host bus.

A single device-wide alternate-function register sits at the top address and is decoded locally. One bit turns every channel write into a broadcast to both channels at once, which shortens start-up when both channels need the same setup. A two-bit field picks what each channel's multi-function output pin shows: a general-purpose output derived from the channel's modem-control register, the channel's 16x baud clock, or its active-low receive-ready signal. The block keeps a shadow of the general-purpose modem-control bit of each channel, so it can drive that pin function itself.

Top module: `duart_host_decode`

## Requirements
- R1: While `cs_n` is high, no read or write enable pulses, and a write strobe changes neither the alternate-function register nor any modem-control shadow.
- R2: With `cs_n` low and the broadcast bit clear, a write strobe with `chan_sel`=1 reaches channel A only, and one with `chan_sel`=0 reaches channel B only. The enable rises in the cycle after the first clock edge that sees the strobe low, with `reg_addr`/`reg_wdata` holding the captured address and data.
- R3: When bit 0 of the alternate-function register is 1, a write to any channel address pulses `wr_en_a` and `wr_en_b` in the same cycle, whatever `chan_sel` is. This includes modem-control writes, which then update both shadows.
- R4: Reads are never broadcast. A read pulses only the enable of the channel named by `chan_sel`, and `host_rdata` carries `rdata_a` when `chan_sel`=1 and `rdata_b` when it is 0.
- R5: A strobe held low for any number of cycles yields exactly one enable pulse, one cycle wide.
- R6: The alternate-function register is at address 7. A write there stores data bits 2:0 (bit 0 broadcast, bits 2:1 pin function) and produces no channel enable. A read there returns `{5'b0, bits}` on `host_rdata`.
- R7: Pin function 2'b00 (general-purpose output) drives the channel's pin low while its shadowed modem-control bit 3 is 1 and high while it is 0. The shadow is loaded from data bit 3 of a write to address 4 of that channel.
- R8: Pin function 2'b01 puts the channel's 16x baud clock input on its pin.
- R9: Pin function 2'b10 puts the channel's active-low receive-ready input on its pin.
- R10: Pin function 2'b11 is reserved and holds both pins high.
- R11: Reset (active high) clears all enables and the alternate-function register and sets both modem-control shadows to 1, so both pins read low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| chan_sel | input | 1 | 1 = channel A, 0 = channel B |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address |
| wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data returned to the host |
| rdata_a | input | 8 | Register read data from channel A |
| rdata_b | input | 8 | Register read data from channel B |
| reg_addr | output | 3 | Captured address for the channel enables |
| reg_wdata | output | 8 | Captured write data for the channel enables |
| wr_en_a | output | 1 | One-cycle write enable, channel A |
| wr_en_b | output | 1 | One-cycle write enable, channel B |
| rd_en_a | output | 1 | One-cycle read enable, channel A |
| rd_en_b | output | 1 | One-cycle read enable, channel B |
| baud16_a | input | 1 | 16x baud clock of channel A |
| baud16_b | input | 1 | 16x baud clock of channel B |
| rxrdy_n_a | input | 1 | Receive-ready, active low, channel A |
| rxrdy_n_b | input | 1 | Receive-ready, active low, channel B |
| mf_a | output | 1 | Multi-function output pin, channel A |
| mf_b | output | 1 | Multi-function output pin, channel B |

## Verification
Writes are issued to each channel with broadcast off, with a short and a long strobe, and then again with broadcast on and `chan_sel` at both values. This separates routing by `chan_sel` from the override and shows that a held strobe is not repeated. Reads are issued with broadcast still set, to show that the override stays on the write side. A write with chip select high targets the alternate-function register and is checked by reading it back. The pin field is stepped through all four codes while the baud, receive-ready and shadow inputs take opposite values on the two channels, so a swapped channel or a wrong mux leg shows up.

// File: rtl/dra_pkg.sv
package dra_pkg;

    typedef enum logic [1:0] {
        MF_GPO   = 2'b00,
        MF_BAUD  = 2'b01,
        MF_RXRDY = 2'b10,
        MF_OFF   = 2'b11
    } mf_sel_e;

    // bit 0 = broadcast, bits 2:1 = pin function
    typedef struct packed {
        mf_sel_e mf;
        logic    bcast;
    } afr_t;

endpackage

// File: rtl/dra_strobe_detect.sv
module dra_strobe_detect (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic start
);
    typedef struct packed {
        logic prev_n;
    } sd_state_t;

    sd_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.prev_n = strobe_n;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{prev_n: 1'b1};
        else     st_q <= st_d;
    end

    assign start = st_q.prev_n & ~strobe_n;

endmodule

// File: rtl/dra_access_decode.sv
module dra_access_decode
    import dra_pkg::*;
#(
    parameter int                ADDR_W   = 3,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] AFR_ADDR = ADDR_W'(7),
    parameter logic [ADDR_W-1:0] MCR_ADDR = ADDR_W'(4),
    parameter int                GPO_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic              rd_start,
    input  logic              cs_n,
    input  logic              chan_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata_a,
    input  logic [DATA_W-1:0] rdata_b,
    output logic [1:0]        wr_en,
    output logic [1:0]        rd_en,
    output afr_t              afr,
    output logic [1:0]        gpo,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    localparam int AFR_W = $bits(afr_t);

    typedef struct packed {
        afr_t              afr;
        logic [1:0]        gpo;
        logic [1:0]        wr_en;
        logic [1:0]        rd_en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       is_afr;
    logic       to_a;
    logic       to_b;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = '0;
        st_d.rd_en = '0;
        is_afr     = (addr == AFR_ADDR);
        to_a       = st_q.afr.bcast | chan_sel;
        to_b       = st_q.afr.bcast | ~chan_sel;

        if (rd_start && !cs_n && !is_afr) begin
            st_d.rd_en = {~chan_sel, chan_sel};
            st_d.addr  = addr;
        end

        if (wr_start && !cs_n) begin
            if (is_afr) begin
                st_d.afr = afr_t'(wdata[AFR_W-1:0]);
            end else begin
                st_d.wr_en = {to_b, to_a};
                st_d.addr  = addr;
                st_d.data  = wdata;
                if (addr == MCR_ADDR) begin
                    if (to_a) st_d.gpo[0] = wdata[GPO_BIT];
                    if (to_b) st_d.gpo[1] = wdata[GPO_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.afr   <= '{mf: MF_GPO, bcast: 1'b0};
            st_q.gpo   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (cs_n)               host_rdata = '0;
        else if (addr == AFR_ADDR) host_rdata = {{(DATA_W-AFR_W){1'b0}}, st_q.afr};
        else if (chan_sel)      host_rdata = rdata_a;
        else                    host_rdata = rdata_b;
    end

    assign wr_en     = st_q.wr_en;
    assign rd_en     = st_q.rd_en;
    assign afr       = st_q.afr;
    assign gpo       = st_q.gpo;
    assign reg_addr  = st_q.addr;
    assign reg_wdata = st_q.data;

    // R6: the alternate-function address is never forwarded to a channel
    a_r6_afr_not_forwarded: assert property (@(posedge clk) disable iff (rst)
        (st_q.wr_en != 2'b00) |-> (st_q.addr != AFR_ADDR));

    // R7: the shadow only moves after a selected write to the modem-control address
    a_r7_gpo_source: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.gpo) |-> $past(wr_start && !cs_n && addr == MCR_ADDR));

endmodule

// File: rtl/dra_mf_mux.sv
module dra_mf_mux
    import dra_pkg::*;
(
    input  mf_sel_e sel,
    input  logic    gpo,
    input  logic    baud16,
    input  logic    rxrdy_n,
    output logic    pin
);
    always_comb begin
        case (sel)
            MF_GPO:   pin = ~gpo;
            MF_BAUD:  pin = baud16;
            MF_RXRDY: pin = rxrdy_n;
            default:  pin = 1'b1;
        endcase
    end
endmodule

// File: rtl/duart_host_decode.sv
module duart_host_decode
    import dra_pkg::*;
#(
    parameter int                ADDR_W   = 3,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] AFR_ADDR = ADDR_W'(7),
    parameter logic [ADDR_W-1:0] MCR_ADDR = ADDR_W'(4),
    parameter int                GPO_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              chan_sel,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [DATA_W-1:0] rdata_a,
    input  logic [DATA_W-1:0] rdata_b,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              wr_en_a,
    output logic              wr_en_b,
    output logic              rd_en_a,
    output logic              rd_en_b,
    input  logic              baud16_a,
    input  logic              baud16_b,
    input  logic              rxrdy_n_a,
    input  logic              rxrdy_n_b,
    output logic              mf_a,
    output logic              mf_b
);
    localparam int NUM_CH = 2;

    logic              wr_start;
    logic              rd_start;
    logic [NUM_CH-1:0] wr_en;
    logic [NUM_CH-1:0] rd_en;
    logic [NUM_CH-1:0] gpo;
    logic [NUM_CH-1:0] baud_v;
    logic [NUM_CH-1:0] rxr_v;
    logic [NUM_CH-1:0] pin_v;
    afr_t              afr;

    dra_strobe_detect u_wr_det (.clk(clk), .rst(rst), .strobe_n(wr_n), .start(wr_start));
    dra_strobe_detect u_rd_det (.clk(clk), .rst(rst), .strobe_n(rd_n), .start(rd_start));

    dra_access_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AFR_ADDR(AFR_ADDR),
        .MCR_ADDR(MCR_ADDR), .GPO_BIT(GPO_BIT)
    ) u_dec (
        .clk(clk), .rst(rst), .wr_start(wr_start), .rd_start(rd_start),
        .cs_n(cs_n), .chan_sel(chan_sel), .addr(addr), .wdata(wdata),
        .rdata_a(rdata_a), .rdata_b(rdata_b), .wr_en(wr_en), .rd_en(rd_en),
        .afr(afr), .gpo(gpo), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .host_rdata(host_rdata)
    );

    assign baud_v = {baud16_b, baud16_a};
    assign rxr_v  = {rxrdy_n_b, rxrdy_n_a};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mf
        dra_mf_mux u_mux (
            .sel(afr.mf), .gpo(gpo[c]), .baud16(baud_v[c]),
            .rxrdy_n(rxr_v[c]), .pin(pin_v[c])
        );
    end

    assign mf_a    = pin_v[0];
    assign mf_b    = pin_v[1];
    assign wr_en_a = wr_en[0];
    assign wr_en_b = wr_en[1];
    assign rd_en_a = rd_en[0];
    assign rd_en_b = rd_en[1];

    // R1: every enable traces back to a selected cycle
    a_r1_no_access_deselected: assert property (@(posedge clk) disable iff (rst)
        (wr_en_a || wr_en_b || rd_en_a || rd_en_b) |-> $past(!cs_n));

    // R2: a lone channel-A write came from chan_sel = 1
    a_r2_route_a: assert property (@(posedge clk) disable iff (rst)
        (wr_en_a && !wr_en_b) |-> $past(chan_sel));

    // R3: a dual write needs the broadcast bit set at the strobe edge
    a_r3_dual_needs_bcast: assert property (@(posedge clk) disable iff (rst)
        (wr_en_a && wr_en_b) |-> $past(afr.bcast));

    // R4: reads never hit both channels
    a_r4_read_single: assert property (@(posedge clk) disable iff (rst)
        rd_en_a |-> !rd_en_b);

    // R5: enables last a single cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (wr_en_a || wr_en_b) |=> !(wr_en_a || wr_en_b));

    // R10: reserved pin code keeps both pins inactive
    a_r10_reserved_high: assert property (@(posedge clk) disable iff (rst)
        (afr.mf == MF_OFF) |-> (mf_a && mf_b));

endmodule

// File: tb/duart_host_decode_tb_top.sv
module duart_host_decode_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       chan_sel = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] rdata_a = 8'hA5;
    logic [7:0] rdata_b = 8'h5B;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       wr_en_a, wr_en_b, rd_en_a, rd_en_b;
    logic [1:0] baud_v = 2'b00;
    logic [1:0] rxr_v  = 2'b11;
    logic       mf_a, mf_b;

    always #2.5 clk = ~clk;

    duart_host_decode dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .chan_sel(chan_sel), .rd_n(rd_n),
        .wr_n(wr_n), .addr(addr), .wdata(wdata), .host_rdata(host_rdata),
        .rdata_a(rdata_a), .rdata_b(rdata_b), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
        .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .baud16_a(baud_v[0]),
        .baud16_b(baud_v[1]), .rxrdy_n_a(rxr_v[0]), .rxrdy_n_b(rxr_v[1]),
        .mf_a(mf_a), .mf_b(mf_b)
    );

    typedef struct {
        logic [3:0] en;     // {rb, ra, wb, wa}
        logic [2:0] a;
        logic [7:0] d;
        bit         chk_d;
        string      req;
    } exp_t;

    exp_t       exp_q[$];
    int         total = 0;
    int         bad = 0;
    logic [2:0] afr_m = 3'b000;
    logic [1:0] gpo_m = 2'b11;

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic exp_pin(input int ch);
        case (afr_m[2:1])
            2'b00:   return ~gpo_m[ch];
            2'b01:   return baud_v[ch];
            2'b10:   return rxr_v[ch];
            default: return 1'b1;
        endcase
    endfunction

    task automatic check_pins(input string req);
        #1;
        check(mf_a === exp_pin(0), {req, " pin A"}, {7'b0, mf_a}, {7'b0, exp_pin(0)});
        check(mf_b === exp_pin(1), {req, " pin B"}, {7'b0, mf_b}, {7'b0, exp_pin(1)});
    endtask

    // driver: predicts the channel enables, pushes them, then drives the bus
    task automatic access(input bit is_wr, input bit cs, input bit sel, input logic [2:0] a,
                          input logic [7:0] d, input int hold, input string req);
        exp_t e;
        logic [7:0] rexp;
        if (!cs) begin
            if (a == 3'd7) begin
                if (is_wr) afr_m = d[2:0];
            end else begin
                e.en[0] = is_wr && (afr_m[0] || sel);
                e.en[1] = is_wr && (afr_m[0] || !sel);
                e.en[2] = !is_wr && sel;
                e.en[3] = !is_wr && !sel;
                e.a = a; e.d = d; e.chk_d = is_wr; e.req = req;
                exp_q.push_back(e);
                if (is_wr && a == 3'd4) begin
                    if (e.en[0]) gpo_m[0] = d[3];
                    if (e.en[1]) gpo_m[1] = d[3];
                end
            end
        end
        cs_n = cs; chan_sel = sel; addr = a; wdata = d;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        repeat (hold) @(negedge clk);
        if (!is_wr && !cs) begin
            #1;
            rexp = (a == 3'd7) ? {5'b0, afr_m} : (sel ? rdata_a : rdata_b);
            check(host_rdata === rexp, {req, " read data"}, host_rdata, rexp);
        end
        wr_n = 1'b1; rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    // monitor: every enable pulse must match the oldest prediction
    always @(negedge clk) begin
        if (!rst && (wr_en_a || wr_en_b || rd_en_a || rd_en_b)) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R1/R5 unexpected enable actual=%b expected=0000",
                         {rd_en_b, rd_en_a, wr_en_b, wr_en_a});
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({rd_en_b, rd_en_a, wr_en_b, wr_en_a} === e.en, {e.req, " enables"},
                      {4'b0, rd_en_b, rd_en_a, wr_en_b, wr_en_a}, {4'b0, e.en});
                check(reg_addr === e.a, {e.req, " reg_addr"}, {5'b0, reg_addr}, {5'b0, e.a});
                if (e.chk_d)
                    check(reg_wdata === e.d, {e.req, " reg_wdata"}, reg_wdata, e.d);
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        #1;
        check({wr_en_a, wr_en_b, rd_en_a, rd_en_b} === 4'b0, "R11 enables idle",
              {4'b0, wr_en_a, wr_en_b, rd_en_a, rd_en_b}, 8'h00);
        check_pins("R11");
        access(1'b0, 1'b0, 1'b1, 3'd7, 8'h00, 1, "R11 afr after reset");

        // R2: routing by chan_sel, broadcast clear
        access(1'b1, 1'b0, 1'b1, 3'd2, 8'h11, 1, "R2 write A");
        access(1'b1, 1'b0, 1'b0, 3'd5, 8'h22, 1, "R2 write B");
        // R5: long strobe, one pulse
        access(1'b1, 1'b0, 1'b1, 3'd3, 8'h44, 6, "R5 held strobe");

        // R1: deselected write to the AFR and MCR does nothing
        access(1'b1, 1'b1, 1'b1, 3'd7, 8'h07, 1, "R1 deselected afr write");
        access(1'b1, 1'b1, 1'b1, 3'd4, 8'h00, 1, "R1 deselected mcr write");
        access(1'b0, 1'b0, 1'b1, 3'd7, 8'h00, 1, "R1 afr unchanged");
        check_pins("R1");

        // R6: AFR write, no channel enable, readback
        access(1'b1, 1'b0, 1'b0, 3'd7, 8'hF9, 1, "R6 afr write");
        access(1'b0, 1'b0, 1'b0, 3'd7, 8'h00, 1, "R6 afr readback");

        // R3: broadcast from both chan_sel values
        access(1'b1, 1'b0, 1'b0, 3'd1, 8'h33, 1, "R3 broadcast sel0");
        access(1'b1, 1'b0, 1'b1, 3'd6, 8'h66, 3, "R3 broadcast sel1");

        // R4: reads with broadcast set stay single
        access(1'b0, 1'b0, 1'b1, 3'd0, 8'h00, 1, "R4 read A");
        access(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 2, "R4 read B");

        // R3/R7: broadcast MCR write clears both shadows
        access(1'b1, 1'b0, 1'b0, 3'd4, 8'h00, 1, "R3 broadcast mcr");
        access(1'b1, 1'b0, 1'b1, 3'd7, 8'h00, 1, "R7 afr gpo mode");
        check_pins("R7 both cleared");
        access(1'b1, 1'b0, 1'b1, 3'd4, 8'h08, 1, "R7 mcr A set");
        check_pins("R7 A set B clear");

        // R8: baud clock
        access(1'b1, 1'b0, 1'b1, 3'd7, 8'h02, 1, "R8 afr baud mode");
        baud_v = 2'b01; check_pins("R8 pattern 01");
        @(negedge clk); baud_v = 2'b10; check_pins("R8 pattern 10");

        // R9: receive-ready
        access(1'b1, 1'b0, 1'b1, 3'd7, 8'h04, 1, "R9 afr rxrdy mode");
        rxr_v = 2'b10; check_pins("R9 pattern 10");
        @(negedge clk); rxr_v = 2'b01; check_pins("R9 pattern 01");

        // R10: reserved code
        access(1'b1, 1'b0, 1'b1, 3'd7, 8'h06, 1, "R10 afr reserved");
        rxr_v = 2'b00; baud_v = 2'b00; check_pins("R10 inputs low");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all predicted enables seen",
              8'(exp_q.size()), 8'h00);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule